// File: doc/BRIEF.md
# Pipelined Digit-Serial Range Matcher

The block decides, for one 16-bit header field such as a transport port, which ranges of a small stored cluster contain it. Every range is an inclusive interval from a lower bound to an upper bound. The key is split into digits of `DIGIT_W` bits (1, 2, 4 or 8), and a pipeline of `KEY_W / DIGIT_W` stages looks at one digit per stage, the most significant first. Each stage keeps only the lower-bound digit and the upper-bound digit of every range that belong to its position. It uses them to advance a small per-range state that says whether the key is still pinned to either bound, already strictly inside, or already outside.

A new key may enter on every clock. After the last stage, a register presents one bit per range together with a valid strobe. Bounds are loaded through a write port that takes a range index and full 16-bit bounds and sends each digit to its stage. Software must keep writes apart from lookups in flight. A lookup that overlaps a write may see either the old or the new bounds.

Top module: `range_matcher`

## Requirements
- R1: For every accepted key, bit r of `match_vec` is 1 exactly when `lo_r <= key <= hi_r`, where `lo_r` and `hi_r` are the bounds last written to range r.
- R2: `match_valid` goes high after the STAGES-th rising edge following the edge that sampled `key_valid` high (4 edges with defaults), once per key, and keys may arrive on consecutive cycles.
- R3: Both bounds are inclusive: a key equal to the lower or the upper bound matches, and a key one below the lower bound or one above the upper bound does not.
- R4: A range whose two bounds are equal matches only that single key value.
- R5: The range [0x0000, 0xFFFF] matches every key, including 0x0000 and 0xFFFF.
- R6: A range written with its lower bound greater than its upper bound matches no key, including keys that lie numerically between the two values.
- R7: A synchronous active-low reset clears `match_valid` and `match_vec` and sets every stored bound to 0, so after reset each range is [0, 0].
- R8: A write with `wr_en` high stores `wr_lo` and `wr_hi` as the bounds of range `wr_idx` and leaves every other range unchanged.
- R9: `match_vec` is all zeros in every cycle in which `match_valid` is low.
- R10: A range that an earlier (more significant) digit has already placed strictly inside or strictly outside keeps that verdict whatever the later digits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| key_valid | input | 1 | A key is presented this cycle |
| key | input | KEY_W | Field value to classify |
| wr_en | input | 1 | Load bounds into one range |
| wr_idx | input | IDX_W | Range index to load |
| wr_lo | input | KEY_W | Inclusive lower bound |
| wr_hi | input | KEY_W | Inclusive upper bound |
| match_valid | output | 1 | `match_vec` holds a result |
| match_vec | output | NUM_RANGES | One match bit per range |

## Verification
The hardest case to reach is a range that stays pinned to both bounds across several digits and only splits near the end. The same goes for a range that is decided early by one digit while later digits would point the other way. Both need keys that share long digit prefixes with the stored bounds. The cluster is therefore loaded with bounds such as [0x1F00, 0x2100], [0x1234, 0x1234] and an inverted pair, and the streamed key table places keys on each bound, one step past each bound, and at values whose low digits would reverse a verdict already taken. Every returned bitmap is compared with a direct `lo <= key <= hi` evaluation over the bench's own copy of the bounds.

// File: rtl/rm_pkg.sv
// Shared types for the range matcher: per-range tracking state and its
// per-digit update rule. Assumes digits are compared most significant first.
package rm_pkg;

    // BOTH: key equals both bound prefixes so far; LB/UB: tight on one bound;
    // IN: strictly between the bounds; OUT: already outside.
    typedef enum logic [2:0] {
        ST_BOTH = 3'd0,
        ST_LB   = 3'd1,
        ST_UB   = 3'd2,
        ST_IN   = 3'd3,
        ST_OUT  = 3'd4
    } rm_state_e;

    // Advance one range's state by one key digit, given the four comparisons.
    function automatic rm_state_e rm_step(input rm_state_e cur,
                                          input logic gt_lo, input logic eq_lo,
                                          input logic lt_hi, input logic eq_hi);
        rm_state_e nxt;
        case (cur)
            ST_BOTH: begin
                if (!(gt_lo || eq_lo) || !(lt_hi || eq_hi)) nxt = ST_OUT;
                else if (eq_lo && eq_hi)                     nxt = ST_BOTH;
                else if (eq_lo)                              nxt = ST_LB;
                else if (eq_hi)                              nxt = ST_UB;
                else                                         nxt = ST_IN;
            end
            ST_LB:   nxt = gt_lo ? ST_IN : (eq_lo ? ST_LB : ST_OUT);
            ST_UB:   nxt = lt_hi ? ST_IN : (eq_hi ? ST_UB : ST_OUT);
            ST_IN:   nxt = ST_IN;
            default: nxt = ST_OUT;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/rm_bound_mem.sv
// Bound digit storage for one pipeline stage: one lower and one upper digit
// per range, written one range at a time, all entries readable at once.
// Assumes writes are kept apart from lookups by the user; reset clears to 0.
module rm_bound_mem #(
    parameter int NUM_RANGES = 16,
    parameter int DIGIT_W    = 4,
    localparam int IDX_W     = (NUM_RANGES > 1) ? $clog2(NUM_RANGES) : 1
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [IDX_W-1:0]                    wr_idx,
    input  logic [DIGIT_W-1:0]                  wr_lo_dig,
    input  logic [DIGIT_W-1:0]                  wr_hi_dig,
    output logic [NUM_RANGES-1:0][DIGIT_W-1:0]  lo_dig,
    output logic [NUM_RANGES-1:0][DIGIT_W-1:0]  hi_dig
);

    // Clear on reset, otherwise update the addressed range's two digits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_dig <= '0;
            hi_dig <= '0;
        end else if (wr_en) begin
            lo_dig[wr_idx] <= wr_lo_dig;
            hi_dig[wr_idx] <= wr_hi_dig;
        end
    end

endmodule

// File: rtl/rm_stage.sv
// One digit stage: compares the key digit with each range's stored bound
// digits (four comparisons per range) and registers the updated states.
// Assumes the incoming states belong to the same key as in_digit.
module rm_stage
    import rm_pkg::*;
#(
    parameter int NUM_RANGES = 16,
    parameter int DIGIT_W    = 4,
    localparam int IDX_W     = (NUM_RANGES > 1) ? $clog2(NUM_RANGES) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_vld,
    input  logic [DIGIT_W-1:0]            in_digit,
    input  rm_state_e [NUM_RANGES-1:0]    in_st,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic [DIGIT_W-1:0]            wr_lo_dig,
    input  logic [DIGIT_W-1:0]            wr_hi_dig,
    output logic                          out_vld,
    output rm_state_e [NUM_RANGES-1:0]    out_st
);

    logic [NUM_RANGES-1:0][DIGIT_W-1:0] lo_dig;
    logic [NUM_RANGES-1:0][DIGIT_W-1:0] hi_dig;
    rm_state_e [NUM_RANGES-1:0]         nxt_st;

    rm_bound_mem #(
        .NUM_RANGES (NUM_RANGES),
        .DIGIT_W    (DIGIT_W)
    ) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_lo_dig (wr_lo_dig),
        .wr_hi_dig (wr_hi_dig),
        .lo_dig    (lo_dig),
        .hi_dig    (hi_dig)
    );

    // Per-range comparisons and state update for this digit position.
    always_comb begin
        for (int r = 0; r < NUM_RANGES; r++) begin
            nxt_st[r] = rm_step(in_st[r],
                                in_digit >  lo_dig[r], in_digit == lo_dig[r],
                                in_digit <  hi_dig[r], in_digit == hi_dig[r]);
        end
    end

    // Pipeline register for the valid flag and the per-range states.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            for (int r = 0; r < NUM_RANGES; r++) out_st[r] <= ST_OUT;
        end else begin
            out_vld <= in_vld;
            out_st  <= nxt_st;
        end
    end

endmodule

// File: rtl/range_matcher.sv
// Range matcher top: a chain of KEY_W/DIGIT_W digit stages, most significant
// digit first, followed by an output register turning final states into a
// match bitmap. Accepts one key per clock; latency is STAGES cycles.
// Assumes DIGIT_W divides KEY_W and DIGIT_W < KEY_W.
module range_matcher
    import rm_pkg::*;
#(
    parameter int KEY_W      = 16,
    parameter int DIGIT_W    = 4,
    parameter int NUM_RANGES = 16,
    localparam int IDX_W     = (NUM_RANGES > 1) ? $clog2(NUM_RANGES) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   key_valid,
    input  logic [KEY_W-1:0]       key,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic [KEY_W-1:0]       wr_lo,
    input  logic [KEY_W-1:0]       wr_hi,
    output logic                   match_valid,
    output logic [NUM_RANGES-1:0]  match_vec
);

    localparam int STAGES = KEY_W / DIGIT_W;

    logic [STAGES-1:0]          stg_vld;
    rm_state_e [NUM_RANGES-1:0] stg_st [STAGES];
    rm_state_e [NUM_RANGES-1:0] seed_st;

    // Every range starts tight on both bounds before the first digit.
    always_comb begin
        for (int r = 0; r < NUM_RANGES; r++) seed_st[r] = ST_BOTH;
    end

    for (genvar g = 0; g < STAGES; g++) begin : g_stg
        localparam int REM_W = KEY_W - g * DIGIT_W;

        logic [REM_W-1:0]           key_at;
        logic                       vld_at;
        rm_state_e [NUM_RANGES-1:0] st_at;

        if (g == 0) begin : g_head
            assign key_at = key;
            assign vld_at = key_valid;
            assign st_at  = seed_st;
        end else begin : g_body
            assign key_at = g_stg[g-1].g_fwd.rest_q;
            assign vld_at = stg_vld[g-1];
            assign st_at  = stg_st[g-1];
        end

        if (g < STAGES - 1) begin : g_fwd
            logic [REM_W-DIGIT_W-1:0] rest_q;
            // Carry only the key digits that later stages still need.
            always_ff @(posedge clk) begin
                if (!rst_n) rest_q <= '0;
                else        rest_q <= key_at[REM_W-DIGIT_W-1:0];
            end
        end

        rm_stage #(
            .NUM_RANGES (NUM_RANGES),
            .DIGIT_W    (DIGIT_W)
        ) u_stage (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_vld    (vld_at),
            .in_digit  (key_at[REM_W-1 -: DIGIT_W]),
            .in_st     (st_at),
            .wr_en     (wr_en),
            .wr_idx    (wr_idx),
            .wr_lo_dig (wr_lo[KEY_W-1-g*DIGIT_W -: DIGIT_W]),
            .wr_hi_dig (wr_hi[KEY_W-1-g*DIGIT_W -: DIGIT_W]),
            .out_vld   (stg_vld[g]),
            .out_st    (stg_st[g])
        );
    end

    // Output register: a range matches unless its final state is OUT.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_valid <= 1'b0;
            match_vec   <= '0;
        end else begin
            match_valid <= stg_vld[STAGES-1];
            for (int r = 0; r < NUM_RANGES; r++) begin
                match_vec[r] <= stg_vld[STAGES-1] && (stg_st[STAGES-1][r] != ST_OUT);
            end
        end
    end

endmodule

// File: rtl/range_matcher_chk.sv
// Checker for range_matcher: output framing after reset, idle outputs,
// result timing relative to the last stage, and persistence of verdicts
// between stages. Attached to every range_matcher instance by bind.
module range_matcher_chk
    import rm_pkg::*;
#(
    parameter int NUM_RANGES = 16,
    parameter int STAGES     = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [STAGES-1:0]          stg_vld,
    input rm_state_e [NUM_RANGES-1:0] stg_st [STAGES],
    input logic                       match_valid,
    input logic [NUM_RANGES-1:0]      match_vec
);

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!match_valid && match_vec == '0)); // R7

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !match_valid |-> match_vec == '0); // R9

    AST_RESULT_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
        match_valid |-> $past(stg_vld[STAGES-1])); // R2

    for (genvar i = 1; i < STAGES; i++) begin : g_hop
        for (genvar r = 0; r < NUM_RANGES; r++) begin : g_rng
            AST_OUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
                (stg_vld[i-1] && stg_st[i-1][r] == ST_OUT) |=> stg_st[i][r] == ST_OUT); // R10
            AST_IN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
                (stg_vld[i-1] && stg_st[i-1][r] == ST_IN) |=> stg_st[i][r] == ST_IN); // R10
        end
    end

endmodule

bind range_matcher range_matcher_chk #(
    .NUM_RANGES (NUM_RANGES),
    .STAGES     (STAGES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .stg_vld     (stg_vld),
    .stg_st      (stg_st),
    .match_valid (match_valid),
    .match_vec   (match_vec)
);

// File: tb/tb_range_matcher.sv
// Self-checking bench for range_matcher. A monitor compares every result
// with a direct lo <= key <= hi model over the bench's own bound copy.
// Requirements covered: R1 R2 R3 R4 R5 R6 R7 R8 R9 R10.
module tb_range_matcher;

    localparam int KW = 16;
    localparam int DW = 4;
    localparam int NR = 16;
    localparam int ST = KW / DW;
    localparam int IW = 4;
    localparam int NV = 24;

    // Cluster contents: index -> [lo, hi].
    localparam logic [15:0] RLO [NR] = '{16'h0000, 16'h1234, 16'h1F00, 16'h0400,
                                         16'h0016, 16'h5000, 16'hFFFF, 16'h0000,
                                         16'h1000, 16'h0100, 16'hABCD, 16'h7FFF,
                                         16'h0443, 16'h0001, 16'h3333, 16'h2000};
    localparam logic [15:0] RHI [NR] = '{16'hFFFF, 16'h1234, 16'h2100, 16'h04FF,
                                         16'h0050, 16'h4000, 16'hFFFF, 16'h0000,
                                         16'h1FFF, 16'h03FF, 16'hABCE, 16'h8000,
                                         16'h4430, 16'hFFFE, 16'h3334, 16'h2000};
    // Streamed keys and the requirement each one targets.
    localparam logic [15:0] VKEY [NV] = '{16'h0000, 16'hFFFF, 16'h1234, 16'h1233,
                                          16'h1235, 16'h1F00, 16'h1EFF, 16'h2100,
                                          16'h2101, 16'h20FF, 16'h0016, 16'h0050,
                                          16'h0015, 16'h0051, 16'h4500, 16'h7FFF,
                                          16'h8000, 16'hABCD, 16'hABCF, 16'h0443,
                                          16'h4430, 16'h4431, 16'h0442, 16'h3334};
    localparam int VTAG [NV] = '{5, 5, 4, 4, 4, 3, 10, 3, 3, 10, 3, 3,
                                 3, 3, 6, 1, 1, 1, 1, 1, 1, 1, 1, 1};

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           key_valid = 1'b0;
    logic [KW-1:0]  key = '0;
    logic           wr_en = 1'b0;
    logic [IW-1:0]  wr_idx = '0;
    logic [KW-1:0]  wr_lo = '0;
    logic [KW-1:0]  wr_hi = '0;
    logic           match_valid;
    logic [NR-1:0]  match_vec;

    logic [15:0] m_lo [NR];
    logic [15:0] m_hi [NR];
    logic [15:0] sent_k [256];
    int          sent_c [256];
    int          sent_t [256];
    int          n_sent = 0;
    int          n_recv = 0;
    int          cyc = 0;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          mon_on = 1'b0;
    bit          done = 1'b0;

    range_matcher #(.KEY_W(KW), .DIGIT_W(DW), .NUM_RANGES(NR)) dut (
        .clk (clk), .rst_n (rst_n), .key_valid (key_valid), .key (key),
        .wr_en (wr_en), .wr_idx (wr_idx), .wr_lo (wr_lo), .wr_hi (wr_hi),
        .match_valid (match_valid), .match_vec (match_vec)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [NR-1:0] model(input logic [15:0] k);
        logic [NR-1:0] v;
        for (int r = 0; r < NR; r++) v[r] = (m_lo[r] <= k) && (k <= m_hi[r]);
        return v;
    endfunction

    task automatic chk(input bit ok, input int tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic send(input logic [15:0] k, input int tag);
        @(negedge clk);
        key_valid = 1'b1;
        key = k;
        sent_k[n_sent] = k;
        sent_c[n_sent] = cyc + 1;
        sent_t[n_sent] = tag;
        n_sent++;
    endtask

    task automatic idle_drain();
        @(negedge clk);
        key_valid = 1'b0;
        while (n_recv != n_sent) @(negedge clk);
    endtask

    task automatic write_range(input int idx, input logic [15:0] lo, input logic [15:0] hi);
        @(negedge clk);
        wr_en = 1'b1;
        wr_idx = IW'(idx);
        wr_lo = lo;
        wr_hi = hi;
        @(negedge clk);
        wr_en = 1'b0;
        m_lo[idx] = lo;
        m_hi[idx] = hi;
    endtask

    // Result monitor: R1 bitmap, R2 latency, R9 quiet vector while idle.
    always @(negedge clk) begin
        if (mon_on) begin
            if (match_valid) begin
                chk(match_vec === model(sent_k[n_recv]), sent_t[n_recv], "bitmap",
                    longint'(match_vec), longint'(model(sent_k[n_recv])));
                chk(cyc - sent_c[n_recv] == ST, 2, "latency",
                    longint'(cyc - sent_c[n_recv]), longint'(ST));
                n_recv++;
            end else begin
                chk(match_vec == '0, 9, "idle vector", longint'(match_vec), 0);
            end
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        for (int r = 0; r < NR; r++) begin
            m_lo[r] = '0;
            m_hi[r] = '0;
        end
        // R7: outputs quiet during reset.
        repeat (3) @(negedge clk);
        chk(match_valid == 1'b0, 7, "valid in reset", longint'(match_valid), 0);
        chk(match_vec == '0, 7, "vector in reset", longint'(match_vec), 0);
        rst_n = 1'b1;
        mon_on = 1'b1;
        // R7: cleared bounds make every range [0,0].
        send(16'h0000, 7);
        send(16'h0001, 7);
        idle_drain();
        // Load the cluster (R8 write path).
        for (int r = 0; r < NR; r++) write_range(r, RLO[r], RHI[r]);
        // Stream the key table back to back (R1 R2 R3 R4 R5 R6 R10).
        for (int i = 0; i < NV; i++) send(VKEY[i], VTAG[i]);
        idle_drain();
        // Gapped traffic: one idle cycle between keys (R2, R9).
        send(16'h0400, 2);
        @(negedge clk);
        key_valid = 1'b0;
        send(16'h04FF, 3);
        idle_drain();
        // R8: rewrite one range only; full bitmap shows others unchanged.
        write_range(15, 16'h0000, 16'h00FF);
        send(16'h0080, 8);
        send(16'h2000, 8);
        send(16'h0100, 8);
        idle_drain();
        chk(n_recv == 31, 2, "result count", longint'(n_recv), 31);
        finish_run();
    end

endmodule